// File: doc/BRIEF.md
# Discriminator Control Register Slave

This block is the control-register slave for a sixteen-channel timing discriminator that sits on a dataflow crate bus. It holds every setting a channel needs: one 8-bit threshold code per channel, a mask word that turns channels off, a byte that packs a dead-time code and an output-width code, and a time-to-charge scale byte. The crate controller addresses the block with a station-select line, a 4-bit subaddress and a 5-bit function code.

The block answers each command combinationally. It asserts X when the command is part of its map and asserts Q when it can carry the command out. For a read command it drives the read bus. Writes and the test-pulse command are applied on the single-cycle S1 strobe. The crate-wide clear line, sampled with the S2 strobe, empties the channel mask and leaves every other register unchanged. The register contents are brought out on ports so that the DAC and timing logic can use them.

Top module: `disc_ctrl_slave`

## Requirements
- R1: After reset every threshold, the channel mask, both timing codes and the scale register read as zero, and `test_pulse` is low.
- R2: Function 16 with subaddress k (0..15) and S1, while station select is high, loads `wdat[7:0]` into the threshold of channel k. Channel k occupies `thr_all[8k+7:8k]`, and the upper data bits are dropped.
- R3: Function 0 with subaddress k returns the threshold of channel k on `rdat[7:0]`, with the upper bits zero.
- R4: Function 17 subaddress 0 loads `wdat[15:0]` into the mask, where bit k set means channel k is masked. Function 1 subaddress 0 reads the mask back.
- R5: Function 17 subaddress 1 loads a byte whose bits 3:0 are the dead-time code and bits 7:4 are the width code. Function 1 subaddress 1 reads that byte back, and `dead_code` and `width_code` show the two fields.
- R6: Function 17 subaddress 2 loads the 8-bit time-to-charge scale. Function 1 subaddress 2 reads it back.
- R7: With station select high, X and Q are both high for these commands: function 0 or 16 with any subaddress, function 1 or 17 with subaddress 0 to 2, and function 25 with subaddress 0.
- R8: Any other function/subaddress pair gives X=0 and Q=0, and with S1 it changes no register.
- R9: With station select low, X, Q and `rdat` are zero and S1 changes nothing. `rdat` is also zero for any command that is not a read.
- R10: The clear line high together with S2 sets the mask to zero on that edge. It leaves the thresholds and the timing and scale bytes unchanged. The clear line without S2 does nothing.
- R11: Function 25 subaddress 0 with S1 and station select raises `test_pulse` for exactly the next clock cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stn | input | 1 | Station select |
| sub | input | 4 | Subaddress |
| fn | input | 5 | Function code |
| s1 | input | 1 | First strobe, one-cycle pulse |
| s2 | input | 1 | Second strobe, one-cycle pulse |
| zclr | input | 1 | Crate-wide clear line |
| wdat | input | 16 | Write data |
| rdat | output | 16 | Read data |
| x_resp | output | 1 | Command recognised |
| q_resp | output | 1 | Command executable |
| test_pulse | output | 1 | One-cycle test strobe |
| thr_all | output | 128 | All channel thresholds, channel k at bits 8k+7:8k |
| chan_mask | output | 16 | Channel mask, 1 = masked |
| dead_code | output | 4 | Dead-time code |
| width_code | output | 4 | Output-width code |
| tq_scale | output | 8 | Time-to-charge scale |

## Verification
The bench probes the edges of the subaddress ranges: function 17 and function 1 at subaddress 3, and function 25 at subaddress 1. A decoder with a loose range would answer these with X and would overwrite a register. It writes a 16-bit word to threshold and timing registers to catch a design that keeps the upper byte. It writes channels 0 and 15 to catch an off-by-one in the per-channel slicing. It pulses the clear line with S2 and then without it, and checks that only the mask is emptied and only when S2 is present; a design that clears too much or ignores the strobe fails here. Writes with station select low and a test command without S1 are checked to cause no side effects.

// File: rtl/disc_ctrl_slave.sv
module disc_ctrl_slave #(
  parameter int CH = 16,
  parameter int TW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stn,
  input  logic [3:0]       sub,
  input  logic [4:0]       fn,
  input  logic             s1,
  input  logic             s2,
  input  logic             zclr,
  input  logic [15:0]      wdat,
  output logic [15:0]      rdat,
  output logic             x_resp,
  output logic             q_resp,
  output logic             test_pulse,
  output logic [CH*TW-1:0] thr_all,
  output logic [CH-1:0]    chan_mask,
  output logic [3:0]       dead_code,
  output logic [3:0]       width_code,
  output logic [7:0]       tq_scale
);
  localparam int AW = $clog2(CH);

  logic [TW-1:0] thr [CH];
  logic [7:0]    tcodes;

  wire thr_ok = {1'b0, sub} < 5'(CH);
  wire rd_thr = fn == 5'd0  && thr_ok;
  wire rd_reg = fn == 5'd1  && sub <= 4'd2;
  wire wr_thr = fn == 5'd16 && thr_ok;
  wire wr_reg = fn == 5'd17 && sub <= 4'd2;
  wire tst    = fn == 5'd25 && sub == 4'd0;
  wire valid  = rd_thr | rd_reg | wr_thr | wr_reg | tst;
  wire go     = s1 & stn;
  wire clr    = zclr & s2;

  assign x_resp = stn & valid;
  assign q_resp = x_resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) thr[i] <= '0;
      chan_mask  <= '0;
      tcodes     <= '0;
      tq_scale   <= '0;
      test_pulse <= 1'b0;
    end else begin
      test_pulse <= go & tst;
      if (go & wr_thr) thr[sub[AW-1:0]] <= wdat[TW-1:0];
      if (clr) chan_mask <= '0;
      else if (go & wr_reg & sub == 4'd0) chan_mask <= wdat[CH-1:0];
      if (go & wr_reg & sub == 4'd1) tcodes   <= wdat[7:0];
      if (go & wr_reg & sub == 4'd2) tq_scale <= wdat[7:0];
    end
  end

  always_comb begin
    rdat = '0;
    if (stn & rd_thr) rdat = 16'(thr[sub[AW-1:0]]);
    else if (stn & rd_reg)
      case (sub)
        4'd0:    rdat = 16'(chan_mask);
        4'd1:    rdat = {8'd0, tcodes};
        default: rdat = {8'd0, tq_scale};
      endcase
  end

  assign dead_code  = tcodes[3:0];
  assign width_code = tcodes[7:4];

  for (genvar g = 0; g < CH; g++) begin : g_thr
    assign thr_all[g*TW +: TW] = thr[g];
  end

  assert_zclr_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zclr && s2) |=> chan_mask == '0);
  assert_zclr_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zclr && s2 && !go) |=> $stable(thr_all) && $stable(tcodes) && $stable(tq_scale));
  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && fn == 5'd17 && sub == 4'd0 && !(zclr && s2)) |=> chan_mask == $past(wdat[CH-1:0]));
  assert_thr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && fn == 5'd16) |=> $stable(thr_all));
  assert_test_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    test_pulse |-> $past(s1 && stn && fn == 5'd25 && sub == 4'd0));
  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stn |-> (rdat == '0 && !x_resp && !q_resp));
endmodule

// File: tb/disc_ctrl_slave_bench.sv
`timescale 1ns/1ps
module disc_ctrl_slave_bench;
  logic clk = 0, rst_n = 0, stn = 0, s1 = 0, s2 = 0, zclr = 0;
  logic [3:0] sub = 0;
  logic [4:0] fn = 0;
  logic [15:0] wdat = 0, rdat;
  logic x_resp, q_resp, test_pulse;
  logic [127:0] thr_all;
  logic [15:0] chan_mask;
  logic [3:0] dead_code, width_code;
  logic [7:0] tq_scale;
  int total = 0, failed = 0;

  always #4 clk = ~clk;

  disc_ctrl_slave u_disc_ctrl_slave (.*);

  // {wf, wa, wd, rf, ra, expected read}
  localparam logic [49:0] TBL [8] = '{
    {5'd16, 4'd3,  16'h005A, 5'd0, 4'd3,  16'h005A},
    {5'd16, 4'd15, 16'h00FF, 5'd0, 4'd15, 16'h00FF},
    {5'd16, 4'd0,  16'h0001, 5'd0, 4'd0,  16'h0001},
    {5'd17, 4'd0,  16'hA5C3, 5'd1, 4'd0,  16'hA5C3},
    {5'd17, 4'd1,  16'h0093, 5'd1, 4'd1,  16'h0093},
    {5'd17, 4'd2,  16'h007E, 5'd1, 4'd2,  16'h007E},
    {5'd17, 4'd1,  16'hFF12, 5'd1, 4'd1,  16'h0012},
    {5'd16, 4'd3,  16'h1234, 5'd0, 4'd3,  16'h0034}
  };

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic n_i, input logic [4:0] f_i, input logic [3:0] a_i,
                     input logic [15:0] d_i, input logic s1_i, input logic s2_i, input logic z_i);
    @(negedge clk);
    stn = n_i; fn = f_i; sub = a_i; wdat = d_i; s1 = s1_i; s2 = s2_i; zclr = z_i;
    @(negedge clk);
    s1 = 0; s2 = 0; zclr = 0; stn = 0;
  endtask

  task automatic rd(input string tag, input logic [4:0] f_i, input logic [3:0] a_i, input logic [15:0] exp);
    stn = 1; fn = f_i; sub = a_i; #1;
    chk(tag, rdat, exp);
    stn = 0; #1;
  endtask

  initial begin
    #(8 * 200000);
    failed++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 thresholds", thr_all, 0);
    chk("R1 mask", chan_mask, 0);
    chk("R1 codes", {dead_code, width_code, tq_scale}, 0);
    chk("R1 test", test_pulse, 0);
    rd("R1 read timing", 5'd1, 4'd1, 0);

    for (int i = 0; i < 8; i++) begin
      cmd(1, TBL[i][49:45], TBL[i][44:41], TBL[i][40:25], 1, 0, 0);
      rd("R2 R3 R4 R5 R6 table readback", TBL[i][24:20], TBL[i][19:16], TBL[i][15:0]);
      stn = 1; fn = TBL[i][24:20]; sub = TBL[i][19:16]; #1;
      chk("R7 read X/Q", {x_resp, q_resp}, 2'b11);
      stn = 0;
    end
    chk("R2 channel 0 slice", thr_all[7:0], 8'h01);
    chk("R2 channel 15 slice", thr_all[127:120], 8'hFF);
    chk("R2 channel 3 slice", thr_all[31:24], 8'h34);
    chk("R5 field ports", {width_code, dead_code}, 8'h12);
    chk("R6 scale port", tq_scale, 8'h7E);
    chk("R4 mask port", chan_mask, 16'hA5C3);

    stn = 1; fn = 5'd16; sub = 4'd9; #1;
    chk("R7 write X/Q", {x_resp, q_resp}, 2'b11);
    chk("R9 rdat zero on write", rdat, 0);
    fn = 5'd25; sub = 0; #1;
    chk("R7 test X/Q", {x_resp, q_resp}, 2'b11);
    chk("R9 rdat zero on test", rdat, 0);
    stn = 0; #1;

    stn = 1; fn = 5'd17; sub = 4'd3; #1; chk("R8 F17 A3 X/Q", {x_resp, q_resp}, 0);
    fn = 5'd1; sub = 4'd3; #1; chk("R8 F1 A3 X/Q", {x_resp, q_resp}, 0); chk("R8 F1 A3 rdat", rdat, 0);
    fn = 5'd25; sub = 4'd1; #1; chk("R8 F25 A1 X/Q", {x_resp, q_resp}, 0);
    fn = 5'd2; sub = 4'd0; #1; chk("R8 F2 X/Q", {x_resp, q_resp}, 0);
    stn = 0; #1;
    cmd(1, 5'd17, 4'd3, 16'hFFFF, 1, 0, 0);
    cmd(1, 5'd18, 4'd0, 16'hFFFF, 1, 0, 0);
    chk("R8 mask unchanged", chan_mask, 16'hA5C3);
    chk("R8 other regs unchanged", {dead_code, width_code, tq_scale, thr_all}, {8'h21, 8'h7E, thr_all});
    rd("R8 timing readback", 5'd1, 4'd1, 16'h0012);

    fn = 5'd0; sub = 4'd3; #1;
    chk("R9 no station", {x_resp, q_resp, rdat}, 0);
    cmd(0, 5'd17, 4'd2, 16'h0055, 1, 0, 0);
    chk("R9 write without station", tq_scale, 8'h7E);
    cmd(1, 5'd17, 4'd2, 16'h0055, 0, 0, 0);
    chk("R9 write without S1", tq_scale, 8'h7E);

    cmd(0, 5'd0, 4'd0, 0, 0, 0, 1);
    chk("R10 clear without S2", chan_mask, 16'hA5C3);
    cmd(0, 5'd0, 4'd0, 0, 0, 1, 1);
    chk("R10 mask cleared", chan_mask, 0);
    rd("R10 mask readback", 5'd1, 4'd0, 0);
    chk("R10 thresholds kept", thr_all[127:120], 8'hFF);
    chk("R10 codes kept", {dead_code, width_code, tq_scale}, {8'h21, 8'h7E});

    @(negedge clk);
    stn = 1; fn = 5'd25; sub = 0; s1 = 1;
    @(negedge clk);
    chk("R11 pulse high", test_pulse, 1);
    s1 = 0; stn = 0;
    @(negedge clk);
    chk("R11 pulse one cycle", test_pulse, 0);
    chk("R11 no register change", {chan_mask, tq_scale}, {16'h0, 8'h7E});
    cmd(1, 5'd25, 4'd0, 0, 0, 0, 0);
    chk("R11 no pulse without S1", test_pulse, 0);
    cmd(1, 5'd25, 4'd1, 0, 1, 0, 0);
    chk("R8 bad test subaddress", test_pulse, 0);

    rst_n = 0; #1;
    chk("R1 reset clears", {thr_all, chan_mask, tq_scale}, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule